// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This unit works out where a small processor fetches next. It takes one 16-bit instruction word, the word after it, the current 14-bit program counter, the 8-bit status register, the 16-bit Z pointer and a return address popped from the stack. It decodes every control-transfer form and produces the next program counter. It also gives a taken flag, a request to push a return address together with that address, and a strobe that sets the interrupt-enable flag.

The result is registered, so it appears one clock after the instruction is offered with `dec_valid`. A small state machine holds the class of the last resolved instruction. It has six states:
- **ST_IDLE**: no result.
- **ST_SEQ**: sequential flow.
- **ST_JUMP**: a taken transfer that is not a call.
- **ST_CALL**: a transfer that pushes a return address.
- **ST_RET**: a plain return.
- **ST_RETI**: a return that also re-enables interrupts.

From any state, a cycle with `dec_valid` high moves the machine to the state picked by the decoded class. A cycle with `dec_valid` low moves it to ST_IDLE. The outputs depend only on the state, plus the registered target and push address.

Top module: `brx_nextpc`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `out_valid`, `taken`, `push_req` and `ie_set` are 0, and `next_pc` and `push_addr` are 0.
- R2: `out_valid` equals `dec_valid` delayed by one clock. When `out_valid` is 0, `taken`, `push_req` and `ie_set` are all 0.
- R3: A word with bits [15:12] = 4'b1100 is a relative jump, and 4'b1101 is a relative call. The target is PC+1 plus the sign-extended 12-bit offset in bits [11:0]. For example, a jump at 0x206 with offset 0xF1C goes to 0x123.
- R4: A word with bits [15:11] = 5'b11110 is a conditional branch. Bits [2:0] pick the status bit, and the index is the `sreg` bit position (7=I, 6=T, 5=H, 4=S, 3=V, 2=N, 1=Z, 0=C). If bit 10 is 0, the branch is taken when the picked bit is 1. If bit 10 is 1, the branch is taken when the picked bit is 0.
- R5: A taken branch goes to PC+1 plus the sign-extended 7-bit offset in bits [9:3], which spans PC+1-64 to PC+1+63. A branch that is not taken gives PC+1 with `taken` at 0.
- R6: A word matching (w & 16'hFE0E) == 16'h940C is a two-word absolute jump, and one matching == 16'h940E is a two-word absolute call. The target is `instr2[13:0]`.
- R7: 16'h9409 is an indirect jump and 16'h9509 is an indirect call. The target is `zptr[13:0]`.
- R8: 16'h9508 (return) and 16'h9518 (return from interrupt) load `ret_addr`. Only the return from interrupt raises `ie_set`.
- R9: Every call form raises `push_req`. `push_addr` is PC+2 for the absolute call and PC+1 for the other calls. Non-call instructions leave `push_req` at 0.
- R10: Any word that matches none of these forms yields PC+1 with `taken` at 0. All address arithmetic wraps modulo 2^14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Instruction word offered this cycle |
| instr | input | 16 | Current instruction word |
| instr2 | input | 16 | Following word (absolute target) |
| pc | input | 14 | Address of the current instruction |
| sreg | input | 8 | Status register |
| zptr | input | 16 | Z pointer for indirect forms |
| ret_addr | input | 14 | Address popped from the stack |
| out_valid | output | 1 | Result present |
| next_pc | output | 14 | Next program counter |
| taken | output | 1 | Control left sequential flow |
| push_req | output | 1 | Push the return address |
| push_addr | output | 14 | Return address to push |
| ie_set | output | 1 | Set the interrupt-enable flag |

## Verification
Some assertions compare outputs with `$past(pc)`. They therefore assume that `pc` is meaningful in the cycle `dec_valid` is high. They also assume that `dec_valid` is low while reset is applied.

The bench drives `dec_valid` low during reset. Each valid word is drawn from one of the encoding classes, or from arbitrary values. The bench pairs it with a random PC, status register, pointer and return address. It never offers a word while reset is applied.

// File: rtl/brx_pkg.sv
package brx_pkg;
    typedef enum logic [3:0] {
        CL_SEQ, CL_REL_JMP, CL_REL_CALL, CL_BRANCH,
        CL_ABS_JMP, CL_ABS_CALL, CL_IND_JMP, CL_IND_CALL,
        CL_RET, CL_RETI
    } brx_class_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_SEQ, ST_JUMP, ST_CALL, ST_RET, ST_RETI
    } brx_state_e;

    typedef struct packed {
        brx_class_e cls;
        logic [11:0] rel_long;
        logic [6:0]  rel_short;
        logic [2:0]  flag_sel;
        logic        on_clear;
    } brx_dec_t;
endpackage

// File: rtl/brx_decode.sv
module brx_decode
    import brx_pkg::*;
#(
    parameter int IW = 16
) (
    input  logic [IW-1:0] word,
    output brx_dec_t      dec
);
    localparam logic [15:0] ABS_MASK = 16'hFE0E;
    localparam logic [15:0] ABS_JMP  = 16'h940C;
    localparam logic [15:0] ABS_CALL = 16'h940E;
    localparam logic [15:0] IND_JMP  = 16'h9409;
    localparam logic [15:0] IND_CALL = 16'h9509;
    localparam logic [15:0] OP_RET   = 16'h9508;
    localparam logic [15:0] OP_RETI  = 16'h9518;

    always_comb begin
        dec.rel_long  = word[11:0];
        dec.rel_short = word[9:3];
        dec.flag_sel  = word[2:0];
        dec.on_clear  = word[10];
        if (word[15:12] == 4'b1100)
            dec.cls = CL_REL_JMP;
        else if (word[15:12] == 4'b1101)
            dec.cls = CL_REL_CALL;
        else if (word[15:11] == 5'b11110)
            dec.cls = CL_BRANCH;
        else if ((word & ABS_MASK) == ABS_JMP)
            dec.cls = CL_ABS_JMP;
        else if ((word & ABS_MASK) == ABS_CALL)
            dec.cls = CL_ABS_CALL;
        else if (word == IND_JMP)
            dec.cls = CL_IND_JMP;
        else if (word == IND_CALL)
            dec.cls = CL_IND_CALL;
        else if (word == OP_RET)
            dec.cls = CL_RET;
        else if (word == OP_RETI)
            dec.cls = CL_RETI;
        else
            dec.cls = CL_SEQ;
    end
endmodule

// File: rtl/brx_cond.sv
module brx_cond #(
    parameter int SW = 8
) (
    input  logic [SW-1:0]         flags,
    input  logic [$clog2(SW)-1:0] sel,
    input  logic                  on_clear,
    output logic                  hit
);
    logic picked;
    assign picked = flags[sel];
    assign hit    = on_clear ? ~picked : picked;
endmodule

// File: rtl/brx_target.sv
module brx_target
    import brx_pkg::*;
#(
    parameter int PC_W = 14,
    parameter int IW   = 16
) (
    input  brx_dec_t        dec,
    input  logic            cond_hit,
    input  logic [PC_W-1:0] pc,
    input  logic [IW-1:0]   word2,
    input  logic [IW-1:0]   zptr,
    input  logic [PC_W-1:0] ret_addr,
    output logic [PC_W-1:0] target,
    output logic [PC_W-1:0] link
);
    localparam int LONG_W  = 12;
    localparam int SHORT_W = 7;

    logic [PC_W-1:0] pc_p1, pc_p2, long_ext, short_ext;
    logic unused_hi;

    assign pc_p1     = pc + PC_W'(1);
    assign pc_p2     = pc + PC_W'(2);
    assign long_ext  = {{(PC_W-LONG_W){dec.rel_long[LONG_W-1]}}, dec.rel_long};
    assign short_ext = {{(PC_W-SHORT_W){dec.rel_short[SHORT_W-1]}}, dec.rel_short};
    assign unused_hi = ^{word2[IW-1:PC_W], zptr[IW-1:PC_W]};

    always_comb begin
        target = pc_p1;
        link   = pc_p1;
        unique case (dec.cls)
            CL_REL_JMP, CL_REL_CALL: target = pc_p1 + long_ext;
            CL_BRANCH:               target = cond_hit ? pc_p1 + short_ext : pc_p1;
            CL_ABS_JMP:              target = word2[PC_W-1:0];
            CL_ABS_CALL: begin
                target = word2[PC_W-1:0];
                link   = pc_p2;
            end
            CL_IND_JMP, CL_IND_CALL: target = zptr[PC_W-1:0];
            CL_RET, CL_RETI:         target = ret_addr;
            default:                 target = pc_p1;
        endcase
    end
endmodule

// File: rtl/brx_nextpc.sv
module brx_nextpc
    import brx_pkg::*;
#(
    parameter int PC_W = 14,
    parameter int IW   = 16,
    parameter int SW   = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            dec_valid,
    input  logic [IW-1:0]   instr,
    input  logic [IW-1:0]   instr2,
    input  logic [PC_W-1:0] pc,
    input  logic [SW-1:0]   sreg,
    input  logic [IW-1:0]   zptr,
    input  logic [PC_W-1:0] ret_addr,
    output logic            out_valid,
    output logic [PC_W-1:0] next_pc,
    output logic            taken,
    output logic            push_req,
    output logic [PC_W-1:0] push_addr,
    output logic            ie_set
);
    localparam int SEL_W = $clog2(SW);

    brx_dec_t        dec;
    logic            cond_hit;
    logic [PC_W-1:0] target, link;
    brx_state_e      state_q, state_d;
    logic [PC_W-1:0] tgt_q, link_q;

    brx_decode #(.IW(IW)) u_decode (
        .word (instr),
        .dec  (dec)
    );

    brx_cond #(.SW(SW)) u_cond (
        .flags    (sreg),
        .sel      (dec.flag_sel[SEL_W-1:0]),
        .on_clear (dec.on_clear),
        .hit      (cond_hit)
    );

    brx_target #(.PC_W(PC_W), .IW(IW)) u_target (
        .dec      (dec),
        .cond_hit (cond_hit),
        .pc       (pc),
        .word2    (instr2),
        .zptr     (zptr),
        .ret_addr (ret_addr),
        .target   (target),
        .link     (link)
    );

    always_comb begin
        state_d = ST_IDLE;
        if (dec_valid) begin
            unique case (dec.cls)
                CL_REL_JMP, CL_ABS_JMP, CL_IND_JMP:   state_d = ST_JUMP;
                CL_REL_CALL, CL_ABS_CALL, CL_IND_CALL: state_d = ST_CALL;
                CL_BRANCH: state_d = cond_hit ? ST_JUMP : ST_SEQ;
                CL_RET:    state_d = ST_RET;
                CL_RETI:   state_d = ST_RETI;
                default:   state_d = ST_SEQ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            tgt_q   <= '0;
            link_q  <= '0;
        end else begin
            state_q <= state_d;
            if (dec_valid) begin
                tgt_q  <= target;
                link_q <= link;
            end
        end
    end

    always_comb begin
        out_valid = 1'b0;
        taken     = 1'b0;
        push_req  = 1'b0;
        ie_set    = 1'b0;
        next_pc   = '0;
        push_addr = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_SEQ: begin
                out_valid = 1'b1;
                next_pc   = tgt_q;
            end
            ST_JUMP, ST_RET: begin
                out_valid = 1'b1;
                taken     = 1'b1;
                next_pc   = tgt_q;
            end
            ST_CALL: begin
                out_valid = 1'b1;
                taken     = 1'b1;
                push_req  = 1'b1;
                next_pc   = tgt_q;
                push_addr = link_q;
            end
            ST_RETI: begin
                out_valid = 1'b1;
                taken     = 1'b1;
                ie_set    = 1'b1;
                next_pc   = tgt_q;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/brx_nextpc_chk.sv
module brx_nextpc_chk #(
    parameter int PC_W = 14
) (
    input logic            clk,
    input logic            rst_n,
    input logic            dec_valid,
    input logic [PC_W-1:0] pc,
    input logic            out_valid,
    input logic [PC_W-1:0] next_pc,
    input logic            taken,
    input logic            push_req,
    input logic [PC_W-1:0] push_addr,
    input logic            ie_set
);
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> out_valid);

    a_r2_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!taken && !push_req && !ie_set));

    a_r9_push_is_taken: assert property (@(posedge clk) disable iff (!rst_n)
        push_req |-> (taken && !ie_set));

    a_r8_ie_on_taken: assert property (@(posedge clk) disable iff (!rst_n)
        ie_set |-> (taken && !push_req));

    a_r10_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid ##1 (out_valid && !taken)) |-> (next_pc == $past(pc) + PC_W'(1)));

    a_r9_link_offset: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid ##1 push_req) |->
            ((push_addr == $past(pc) + PC_W'(1)) || (push_addr == $past(pc) + PC_W'(2))));
endmodule

bind brx_nextpc brx_nextpc_chk #(.PC_W(PC_W)) u_brx_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dec_valid (dec_valid),
    .pc        (pc),
    .out_valid (out_valid),
    .next_pc   (next_pc),
    .taken     (taken),
    .push_req  (push_req),
    .push_addr (push_addr),
    .ie_set    (ie_set)
);

// File: tb/test_brx_nextpc.sv
module test_brx_nextpc;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dec_valid = 1'b0;
    logic [15:0] instr = '0, instr2 = '0, zptr = '0;
    logic [13:0] pc = '0, ret_addr = '0;
    logic [7:0]  sreg = '0;
    logic        out_valid, taken, push_req, ie_set;
    logic [13:0] next_pc, push_addr;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    brx_nextpc i_brx_nextpc (
        .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .instr(instr),
        .instr2(instr2), .pc(pc), .sreg(sreg), .zptr(zptr), .ret_addr(ret_addr),
        .out_valid(out_valid), .next_pc(next_pc), .taken(taken),
        .push_req(push_req), .push_addr(push_addr), .ie_set(ie_set)
    );

    // expected {taken, push, ie, next[13:0], link[13:0]}
    function automatic logic [30:0] model(input logic [15:0] w, input logic [15:0] w2,
                                          input logic [13:0] p, input logic [7:0] s,
                                          input logic [15:0] z, input logic [13:0] r);
        logic [13:0] nx, lk, seq;
        logic tk, pu, ie, hit;
        seq = p + 14'd1;
        nx = seq; lk = 14'd0; tk = 1'b0; pu = 1'b0; ie = 1'b0;
        if (w[15:12] == 4'hC || w[15:12] == 4'hD) begin          // R3
            nx = seq + {{2{w[11]}}, w[11:0]};
            tk = 1'b1;
            if (w[12]) begin pu = 1'b1; lk = seq; end
        end else if (w[15:11] == 5'b11110) begin                 // R4 R5
            hit = s[w[2:0]] ^ w[10];
            if (hit) begin nx = seq + {{7{w[9]}}, w[9:3]}; tk = 1'b1; end
        end else if ((w & 16'hFE0E) == 16'h940C) begin           // R6
            nx = w2[13:0]; tk = 1'b1;
        end else if ((w & 16'hFE0E) == 16'h940E) begin           // R6 R9
            nx = w2[13:0]; tk = 1'b1; pu = 1'b1; lk = p + 14'd2;
        end else if (w == 16'h9409) begin                        // R7
            nx = z[13:0]; tk = 1'b1;
        end else if (w == 16'h9509) begin
            nx = z[13:0]; tk = 1'b1; pu = 1'b1; lk = seq;
        end else if (w == 16'h9508) begin                        // R8
            nx = r; tk = 1'b1;
        end else if (w == 16'h9518) begin
            nx = r; tk = 1'b1; ie = 1'b1;
        end
        return {tk, pu, ie, nx, lk};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // offer one word at negedge, compare at the next negedge
    task automatic step(input string req, input logic [15:0] w, input logic [15:0] w2,
                        input logic [13:0] p, input logic [7:0] s,
                        input logic [15:0] z, input logic [13:0] r);
        logic [30:0] e;
        dec_valid = 1'b1; instr = w; instr2 = w2; pc = p; sreg = s; zptr = z; ret_addr = r;
        e = model(w, w2, p, s, z, r);
        @(negedge clk);
        check({req, " valid"}, {31'd0, out_valid}, 32'd1);
        check({req, " flags"}, {29'd0, taken, push_req, ie_set}, {29'd0, e[30:28]});
        check({req, " next"}, {18'd0, next_pc}, {18'd0, e[27:14]});
        if (e[29]) check({req, " link"}, {18'd0, push_addr}, {18'd0, e[13:0]});
    endtask

    function automatic logic [15:0] pick_word();
        logic [15:0] w;
        w = 16'($urandom);
        case ($urandom % 9)
            0: w = {4'hC, w[11:0]};
            1: w = {4'hD, w[11:0]};
            2, 3: w = {5'b11110, w[10:0]};
            4: w = (w & ~16'hFE0E) | (($urandom % 2) ? 16'h940E : 16'h940C);
            5: w = ($urandom % 2) ? 16'h9409 : 16'h9509;
            6: w = ($urandom % 2) ? 16'h9508 : 16'h9518;
            default: ;
        endcase
        return w;
    endfunction

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check("R1 reset outputs", {out_valid, taken, push_req, ie_set, next_pc, push_addr},
              32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 post-reset idle", {out_valid, taken, push_req, ie_set, next_pc, push_addr},
              32'd0);

        // R3 worked example and relative call
        step("R3 rjmp back", 16'hCF1C, 16'h0, 14'h206, 8'h0, 16'h0, 14'h0);
        check("R3 target 0x123", {18'd0, next_pc}, 32'h123);
        step("R3 rcall fwd", 16'hD005, 16'h0, 14'h100, 8'h0, 16'h0, 14'h0);
        // R4 R5 branch extremes and polarity
        step("R5 branch -64", 16'hF200 | 16'h0001, 16'h0, 14'h300, 8'h02, 16'h0, 14'h0);
        check("R5 target -64", {18'd0, next_pc}, 32'h301 - 32'd64);
        step("R5 branch +63", 16'hF000 | (16'd63 << 3) | 16'h0007, 16'h0, 14'h300, 8'h80,
             16'h0, 14'h0);
        step("R4 clear not taken", 16'hF400 | (16'd5 << 3) | 16'h0001, 16'h0, 14'h40, 8'h02,
             16'h0, 14'h0);
        step("R4 clear taken", 16'hF400 | (16'd5 << 3) | 16'h0006, 16'h0, 14'h40, 8'hBF,
             16'h0, 14'h0);
        // R6 R7 R8 R9
        step("R6 abs call", 16'h940E, 16'h2ABC, 14'h3FFF, 8'h0, 16'h0, 14'h0);
        step("R7 icall", 16'h9509, 16'h0, 14'h10, 8'h0, 16'hC123, 14'h0);
        step("R8 reti", 16'h9518, 16'h0, 14'h10, 8'h0, 16'h0, 14'h1555);
        step("R8 ret", 16'h9508, 16'h0, 14'h10, 8'h0, 16'h0, 14'h0AAA);
        // R10 wrap on unrelated word
        step("R10 wrap", 16'h0000, 16'h0, 14'h3FFF, 8'hFF, 16'h0, 14'h0);
        check("R10 wrap to zero", {18'd0, next_pc}, 32'd0);
        // R2 gap
        dec_valid = 1'b0;
        @(negedge clk);
        check("R2 idle after gap", {28'd0, out_valid, taken, push_req, ie_set}, 32'd0);

        for (int i = 0; i < 400; i++) begin
            if (($urandom % 10) == 0) begin
                dec_valid = 1'b0;
                @(negedge clk);
                check("R2 gap", {28'd0, out_valid, taken, push_req, ie_set}, 32'd0);
            end
            step("R3..R10 random", pick_word(), 16'($urandom), 14'($urandom),
                 8'($urandom), 16'($urandom), 14'($urandom));
        end
        dec_valid = 1'b0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule